// File: doc/BRIEF.md
# Memory Browser and Result Display Controller

This controller produces the segment patterns for a four-digit hexadecimal display in a memory-sorting system. In browse mode it keeps an 8-bit current address. The up and down buttons step that address. The address drives a synchronous memory read port. The display shows the address on the two upper digits and the returned byte on the two lower digits.

A sort-start event switches the display to dashes on all four digits, and the controller stays there until the sort-done event. After that it shows one 16-bit half of a 32-bit cycle count. Two switches pick the half and pick between the software count and the hardware count. Any button other than select brings the display back to browse mode. An init-done event also forces browse mode, from any mode.

Digit scanning, debouncing and the sorting engine lie outside this block. Buttons and events arrive as single-cycle pulses.

Top module: `mvd_top`

## Requirements
- R1: After reset the controller is in browse mode with the current address at 00.
- R2: In browse mode, digits 3..2 show the current address and digits 1..0 show `mem_rdata_i`. The memory returns data one cycle after `mem_addr_o` changes, so after a step the lower digits show the old byte for one cycle.
- R3: In browse mode, each up pulse adds one to the address and each down pulse subtracts one. Up and down in the same cycle leave the address unchanged.
- R4: The address wraps modulo 256: up from FF gives 00, and down from 00 gives FF.
- R5: A sort-start pulse puts all four digits to the dash pattern 7'h40. In this mode all buttons are ignored and the address is unchanged.
- R6: A sort-done pulse while dashes are shown enters result mode. `sw_half_i`=0 shows count bits 15:0 and `sw_half_i`=1 shows bits 31:16, with digit 3 holding the most significant nibble.
- R7: In result mode, `sw_src_i`=0 shows `sw_cnt_i` and `sw_src_i`=1 shows `hw_cnt_i`. A switch change takes effect on the display in the same cycle.
- R8: In result mode, a pulse on up, down, left or right returns to browse mode without stepping the address. A select pulse leaves result mode unchanged.
- R9: An init-done pulse returns to browse mode from any mode. Event priority within one cycle is init-done, then sort-done, then sort-start, then buttons.
- R10: Segment bits per digit are {g,f,e,d,c,b,a}, active high, and digit d occupies `seg_o[7d+6:7d]`. The codes for 0..F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_up_i | input | 1 | Up button pulse |
| btn_dn_i | input | 1 | Down button pulse |
| btn_lt_i | input | 1 | Left button pulse |
| btn_rt_i | input | 1 | Right button pulse |
| btn_sel_i | input | 1 | Select button pulse |
| sort_start_i | input | 1 | Sort has begun (pulse) |
| sort_done_i | input | 1 | Sort has finished (pulse) |
| init_done_i | input | 1 | Memory initialisation finished (pulse) |
| sw_half_i | input | 1 | Count half select: 0 low, 1 high |
| sw_src_i | input | 1 | Count source: 0 software, 1 hardware |
| sw_cnt_i | input | 32 | Software cycle count |
| hw_cnt_i | input | 32 | Hardware cycle count |
| mem_addr_o | output | 8 | Memory read address |
| mem_rdata_i | input | 8 | Memory read data, one cycle after address |
| seg_o | output | 28 | Segment patterns, 7 bits per digit |

## Verification
The bench steps the address across both wrap points. A design with a wrong wrap would show 100 or stall at the boundary. It presses up and down together, which exposes a design that lets one of them win. It checks the lower digits in the cycle straight after a step, where they must still hold the old byte; a design that shortcut or double-registered the read would show the wrong value there. It also presses buttons while dashes are shown and as the exit from result mode. A design that stepped the address there would come back to browse at a different address. Same-cycle event collisions expose a design with the wrong priority.

// File: rtl/mvd_pkg.sv
package mvd_pkg;
  typedef enum logic [1:0] {
    MODE_BROWSE = 2'd0,
    MODE_BUSY   = 2'd1,
    MODE_RESULT = 2'd2
  } mode_e;

  localparam logic [6:0] SEG_DASH = 7'h40;
endpackage

// File: rtl/mvd_addr_step.sv
module mvd_addr_step #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              up_i,
  input  logic              dn_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic step;
  assign step = en_i & (up_i ^ dn_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  addr_o <= '0;
    else if (step) addr_o <= up_i ? addr_o + 1'b1 : addr_o - 1'b1;
  end

  AST_ADDR_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && up_i && !dn_i) |=> addr_o == $past(addr_o) + 1'b1); // R4
  AST_ADDR_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dn_i && !up_i) |=> addr_o == $past(addr_o) - 1'b1); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || (up_i == dn_i)) |=> $stable(addr_o)); // R5
endmodule

// File: rtl/mvd_mode_fsm.sv
module mvd_mode_fsm
  import mvd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sort_start_i,
  input  logic  sort_done_i,
  input  logic  init_done_i,
  input  logic  exit_btn_i,
  output mode_e mode_o
);
  mode_e mode_d;

  always_comb begin
    mode_d = mode_o;
    if (init_done_i)                              mode_d = MODE_BROWSE;
    else if (sort_done_i && mode_o == MODE_BUSY)  mode_d = MODE_RESULT;
    else if (sort_start_i)                        mode_d = MODE_BUSY;
    else if (exit_btn_i && mode_o == MODE_RESULT) mode_d = MODE_BROWSE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= MODE_BROWSE;
    else         mode_o <= mode_d;
  end

  AST_INIT_BROWSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_i |=> mode_o == MODE_BROWSE); // R9
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sort_start_i && !init_done_i && !(sort_done_i && mode_o == MODE_BUSY))
    |=> mode_o == MODE_BUSY); // R5
  AST_RESULT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_RESULT && exit_btn_i && !init_done_i && !sort_start_i)
    |=> mode_o == MODE_BROWSE); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_RESULT && !exit_btn_i && !init_done_i && !sort_start_i)
    |=> mode_o == MODE_RESULT); // R8
endmodule

// File: rtl/mvd_hex7.sv
module mvd_hex7
  import mvd_pkg::*;
(
  input  logic [3:0] nib_i,
  input  logic       dash_i,
  output logic [6:0] seg_o
);
  logic [6:0] code;

  always_comb begin
    unique case (nib_i)
      4'h0: code = 7'h3F;
      4'h1: code = 7'h06;
      4'h2: code = 7'h5B;
      4'h3: code = 7'h4F;
      4'h4: code = 7'h66;
      4'h5: code = 7'h6D;
      4'h6: code = 7'h7D;
      4'h7: code = 7'h07;
      4'h8: code = 7'h7F;
      4'h9: code = 7'h6F;
      4'hA: code = 7'h77;
      4'hB: code = 7'h7C;
      4'hC: code = 7'h39;
      4'hD: code = 7'h5E;
      4'hE: code = 7'h79;
      default: code = 7'h71;
    endcase
  end

  assign seg_o = dash_i ? SEG_DASH : code;
endmodule

// File: rtl/mvd_top.sv
module mvd_top
  import mvd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 32,
  parameter int DIGITS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                btn_up_i,
  input  logic                btn_dn_i,
  input  logic                btn_lt_i,
  input  logic                btn_rt_i,
  input  logic                btn_sel_i,
  input  logic                sort_start_i,
  input  logic                sort_done_i,
  input  logic                init_done_i,
  input  logic                sw_half_i,
  input  logic                sw_src_i,
  input  logic [CNT_W-1:0]    sw_cnt_i,
  input  logic [CNT_W-1:0]    hw_cnt_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic [DIGITS*7-1:0] seg_o
);
  localparam int WORD_W = DIGITS * 4;
  localparam int HALF_W = CNT_W / 2;

  mode_e             mode;
  logic              exit_btn;
  logic [CNT_W-1:0]  cnt_sel;
  logic [WORD_W-1:0] word;
  logic              dash;

  // select is excluded: it must not leave result mode
  assign exit_btn = btn_up_i | btn_dn_i | btn_lt_i | btn_rt_i;

  mvd_mode_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sort_start_i (sort_start_i),
    .sort_done_i  (sort_done_i),
    .init_done_i  (init_done_i),
    .exit_btn_i   (exit_btn),
    .mode_o       (mode)
  );

  mvd_addr_step #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (mode == MODE_BROWSE),
    .up_i   (btn_up_i),
    .dn_i   (btn_dn_i),
    .addr_o (mem_addr_o)
  );

  assign cnt_sel = sw_src_i ? hw_cnt_i : sw_cnt_i;
  assign dash    = (mode == MODE_BUSY);

  always_comb begin
    word = '0;
    if (mode == MODE_RESULT)
      word = WORD_W'(sw_half_i ? cnt_sel[CNT_W-1:HALF_W] : cnt_sel[HALF_W-1:0]);
    else if (mode == MODE_BROWSE)
      word = WORD_W'({mem_addr_o, mem_rdata_i});
  end

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    mvd_hex7 u_hex (
      .nib_i  (word[4*d +: 4]),
      .dash_i (dash),
      .seg_o  (seg_o[7*d +: 7])
    );
  end

  AST_DASH_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == MODE_BUSY) |-> seg_o == {DIGITS{SEG_DASH}}); // R5
endmodule

// File: tb/sim_mvd_top.sv
module sim_mvd_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] btn = '0;   // {sel, rt, lt, dn, up}
  logic [2:0] evt = '0;   // {init_done, sort_done, sort_start}
  logic sw_half = 1'b0, sw_src = 1'b0;
  logic [31:0] sw_cnt = '0, hw_cnt = '0;
  logic [7:0] addr, rdata;
  logic [27:0] seg;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mval(input logic [7:0] a);
    return 8'(a * 8'd37 + 8'd11);
  endfunction

  always_ff @(posedge clk) rdata <= mval(addr);

  mvd_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .btn_up_i(btn[0]), .btn_dn_i(btn[1]), .btn_lt_i(btn[2]),
    .btn_rt_i(btn[3]), .btn_sel_i(btn[4]),
    .sort_start_i(evt[0]), .sort_done_i(evt[1]), .init_done_i(evt[2]),
    .sw_half_i(sw_half), .sw_src_i(sw_src),
    .sw_cnt_i(sw_cnt), .hw_cnt_i(hw_cnt),
    .mem_addr_o(addr), .mem_rdata_i(rdata), .seg_o(seg)
  );

  function automatic logic [6:0] enc(input logic [3:0] n);
    case (n)
      4'h0: enc = 7'h3F; 4'h1: enc = 7'h06; 4'h2: enc = 7'h5B; 4'h3: enc = 7'h4F;
      4'h4: enc = 7'h66; 4'h5: enc = 7'h6D; 4'h6: enc = 7'h7D; 4'h7: enc = 7'h07;
      4'h8: enc = 7'h7F; 4'h9: enc = 7'h6F; 4'hA: enc = 7'h77; 4'hB: enc = 7'h7C;
      4'hC: enc = 7'h39; 4'hD: enc = 7'h5E; 4'hE: enc = 7'h79; default: enc = 7'h71;
    endcase
  endfunction

  function automatic logic [27:0] wexp(input logic [15:0] v);
    return {enc(v[15:12]), enc(v[11:8]), enc(v[7:4]), enc(v[3:0])};
  endfunction

  localparam logic [27:0] DASHES = {4{7'h40}};

  // {src, half, sw_cnt, hw_cnt, expected}
  localparam logic [81:0] VEC [6] = '{
    {1'b0, 1'b0, 32'h89AB_CDEF, 32'h0123_4567, 16'hCDEF},
    {1'b0, 1'b1, 32'h89AB_CDEF, 32'h0123_4567, 16'h89AB},
    {1'b1, 1'b0, 32'h89AB_CDEF, 32'h0123_4567, 16'h4567},
    {1'b1, 1'b1, 32'h89AB_CDEF, 32'h0123_4567, 16'h0123},
    {1'b1, 1'b1, 32'hFFFF_0000, 32'h00FF_F00F, 16'h00FF},
    {1'b0, 1'b0, 32'hFFFF_0000, 32'h00FF_F00F, 16'h0000}
  };

  task automatic chk(input string req, input logic [27:0] act, input logic [27:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: seg act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic press(input logic [4:0] b);
    btn = b;
    @(negedge clk);
    btn = '0;
  endtask

  task automatic event_(input logic [2:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(5 * 20000);
    n_err++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1", seg, wexp({8'h00, mval(8'h00)}));

    press(5'b00001);
    chk("R2 lag", seg, wexp({8'h01, mval(8'h00)}));
    tick();
    chk("R2", seg, wexp({8'h01, mval(8'h01)}));

    press(5'b00010);
    tick();
    chk("R3 down", seg, wexp({8'h00, mval(8'h00)}));
    press(5'b00010);
    tick();
    chk("R4 wrap down", seg, wexp({8'hFF, mval(8'hFF)}));
    press(5'b00001);
    tick();
    chk("R4 wrap up", seg, wexp({8'h00, mval(8'h00)}));

    press(5'b00011);
    tick();
    chk("R3 both", seg, wexp({8'h00, mval(8'h00)}));

    repeat (3) press(5'b00001);
    tick();
    chk("R3 up x3", seg, wexp({8'h03, mval(8'h03)}));

    event_(3'b001);
    chk("R5 dash", seg, DASHES);
    press(5'b00001);
    press(5'b01000);
    chk("R5 ignore btn", seg, DASHES);

    event_(3'b010);
    for (int i = 0; i < 6; i++) begin
      sw_src  = VEC[i][81];
      sw_half = VEC[i][80];
      sw_cnt  = VEC[i][79:48];
      hw_cnt  = VEC[i][47:16];
      #1;
      chk("R6 R7 R10", seg, wexp(VEC[i][15:0]));
      tick();
    end

    press(5'b10000);
    chk("R8 select", seg, wexp(16'h0000));

    press(5'b00100);
    chk("R8 exit R5 addr", seg, wexp({8'h03, mval(8'h03)}));

    event_(3'b001);
    event_(3'b010);
    press(5'b00001);
    tick();
    chk("R8 no step", seg, wexp({8'h03, mval(8'h03)}));

    event_(3'b001);
    event_(3'b100);
    chk("R9 from busy", seg, wexp({8'h03, mval(8'h03)}));

    event_(3'b001);
    event_(3'b010);
    event_(3'b100);
    chk("R9 from result", seg, wexp({8'h03, mval(8'h03)}));

    event_(3'b101);
    chk("R9 priority", seg, wexp({8'h03, mval(8'h03)}));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule